// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block gathers interrupt events from a parameterised number of sources and decides which service entry address the processor core branches to. Every source owns three bits: a pending flag that its event pulse sets, an enable that lets the flag raise a request, and a priority selector. A control register holds two global gates and a mode bit. With the mode bit clear, all requests share one entry address; bit 7 is the master gate and bit 6 additionally gates the peripheral sources, while core sources ignore bit 6. With the mode bit set, bit 7 gates the high level and bit 6 gates the low level.

The core sees a request line and an entry address. When it branches, it pulses a take strobe. The controller then closes the gate of the level it entered and records that level as active. A return strobe leaves the innermost active level and reopens its gate. A high-level request may interrupt a running low-level routine, and the low routine stays active underneath it. A low-level request is never granted while a high-level routine runs.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After synchronous reset all control, enable, flag and priority bits are 0, no level is active, `irq_req` is 0 and `vec_addr` is the idle address 0x000000.
- R2: An event pulse on source i sets flag i whatever its enable is. The flag stays set until software writes register 2 with bit i at 0.
- R3: A source contributes to a request only while both its flag and its enable are 1.
- R4: With control bit 0 at 0 (single level), a pending source raises `irq_req` with `vec_addr` 0x000008 while control bit 7 is 1. Sources N_CORE and above also need control bit 6, and sources below N_CORE do not.
- R5: With control bit 0 at 1 (two levels), a pending source whose priority bit is 1 requests 0x000008 gated by control bit 7, and one whose priority bit is 0 requests 0x000018 gated by control bit 6. When both levels request, 0x000008 is presented.
- R6: A `vec_take` pulse while the high address is requested clears control bit 7 and sets `in_high`. While the low address is requested, it clears control bit 6 and sets `in_low`.
- R7: A high request is granted while `in_low` is 1 (preemption). No low request is presented while `in_high` is 1, even with bit 6 set.
- R8: A `reti` pulse clears `in_high` and sets control bit 7 if `in_high` is 1. Otherwise it clears `in_low` and sets control bit 6 if `in_low` is 1. A low routine underneath survives the return from the high one.
- R9: Register map: address 0 is control (bit 7 high gate, bit 6 low or peripheral gate, bit 0 mode, other bits read 0), address 1 is enables, address 2 is flags, address 3 is priorities, with bit i for source i. Writes read back on `reg_rdata`.
- R10: An event on a source in the same cycle as a flag-register write leaves that flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | N_SRC | Per-source event pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read data of the selected register |
| vec_take | input | 1 | Core has branched to the presented address |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request to the core |
| vec_addr | output | AW | Entry address of the pending request |
| in_high | output | 1 | High-level routine active |
| in_low | output | 1 | Low-level routine active |

## Verification
A wrong level record or a gate bit left in the wrong state shows up one cycle after the take or return strobe. It appears as a control register that reads back with the wrong bits, as a request line that stays silent when a pending source should get through, or as a low address presented under a running high routine. Each scenario reads the control register and watches `irq_req`, `vec_addr`, `in_high` and `in_low` in the cycle after each strobe. Any error in the nesting bookkeeping therefore surfaces within one clock of the event that exposes it.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int CTRL_HI_BIT   = 7;
    localparam int CTRL_LO_BIT   = 6;
    localparam int CTRL_MODE_BIT = 0;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_EN   = 2'd1,
        REG_FLAG = 2'd2,
        REG_PRIO = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        GRANT_NONE = 2'd0,
        GRANT_LOW  = 2'd1,
        GRANT_HIGH = 2'd2
    } grant_e;

    typedef struct packed {
        logic hi_en;
        logic lo_en;
        logic mode;
    } ctrl_t;

    function automatic logic [7:0] ctrl_to_byte(ctrl_t c);
        logic [7:0] b;
        b = '0;
        b[CTRL_HI_BIT]   = c.hi_en;
        b[CTRL_LO_BIT]   = c.lo_en;
        b[CTRL_MODE_BIT] = c.mode;
        return b;
    endfunction

    function automatic ctrl_t byte_to_ctrl(logic [7:0] b);
        ctrl_t c;
        c.hi_en = b[CTRL_HI_BIT];
        c.lo_en = b[CTRL_LO_BIT];
        c.mode  = b[CTRL_MODE_BIT];
        return c;
    endfunction

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] evt,
    input  logic             wr_en_reg,
    input  logic             wr_flag_reg,
    input  logic             wr_prio_reg,
    input  logic [N_SRC-1:0] wdata,
    output logic [N_SRC-1:0] en_q,
    output logic [N_SRC-1:0] flag_q,
    output logic [N_SRC-1:0] prio_q
);

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[i]   <= 1'b0;
                flag_q[i] <= 1'b0;
                prio_q[i] <= 1'b0;
            end else begin
                if (wr_en_reg)
                    en_q[i] <= wdata[i];
                if (wr_prio_reg)
                    prio_q[i] <= wdata[i];
                // hardware set dominates a software write in the same cycle
                if (evt[i])
                    flag_q[i] <= 1'b1;
                else if (wr_flag_reg)
                    flag_q[i] <= wdata[i];
            end
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int          N_SRC   = 8,
    parameter int          N_CORE  = 2,
    parameter int          AW      = 21,
    parameter logic [AW-1:0] VEC_IDLE = '0,
    parameter logic [AW-1:0] VEC_HI   = 8,
    parameter logic [AW-1:0] VEC_LO   = 24
) (
    input  logic [N_SRC-1:0] en,
    input  logic [N_SRC-1:0] flag,
    input  logic [N_SRC-1:0] prio,
    input  ctrl_t            ctrl,
    input  logic             in_high,
    input  logic             in_low,
    output logic             irq_req,
    output logic [AW-1:0]    vec_addr,
    output grant_e           grant
);

    logic [N_SRC-1:0] core_mask;
    logic [N_SRC-1:0] pend;
    logic             req_hi;
    logic             req_lo;

    for (genvar i = 0; i < N_SRC; i++) begin : g_mask
        assign core_mask[i] = (i < N_CORE);
    end

    assign pend = en & flag;

    always_comb begin
        if (ctrl.mode) begin
            req_hi = ctrl.hi_en && !in_high && |(pend & prio);
            req_lo = ctrl.lo_en && !in_high && !in_low && |(pend & ~prio);
        end else begin
            req_hi = ctrl.hi_en && !in_high &&
                     |(pend & (core_mask | {N_SRC{ctrl.lo_en}}));
            req_lo = 1'b0;
        end
    end

    always_comb begin
        if (req_hi) begin
            grant    = GRANT_HIGH;
            vec_addr = VEC_HI;
        end else if (req_lo) begin
            grant    = GRANT_LOW;
            vec_addr = VEC_LO;
        end else begin
            grant    = GRANT_NONE;
            vec_addr = VEC_IDLE;
        end
    end

    assign irq_req = req_hi | req_lo;

endmodule

// File: rtl/irq_level_ctl.sv
module irq_level_ctl
    import irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_ctrl,
    input  logic [7:0] wbyte,
    input  grant_e     taken,
    input  logic       reti,
    output ctrl_t      ctrl_q,
    output logic       in_high,
    output logic       in_low
);

    ctrl_t ctrl_d;
    logic  hi_d;
    logic  lo_d;

    always_comb begin
        ctrl_d = ctrl_q;
        hi_d   = in_high;
        lo_d   = in_low;
        if (wr_ctrl)
            ctrl_d = byte_to_ctrl(wbyte);
        if (reti) begin
            if (in_high) begin
                hi_d         = 1'b0;
                ctrl_d.hi_en = 1'b1;
            end else if (in_low) begin
                lo_d         = 1'b0;
                ctrl_d.lo_en = 1'b1;
            end
        end
        case (taken)
            GRANT_HIGH: begin
                hi_d         = 1'b1;
                ctrl_d.hi_en = 1'b0;
            end
            GRANT_LOW: begin
                lo_d         = 1'b1;
                ctrl_d.lo_en = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            in_high <= 1'b0;
            in_low  <= 1'b0;
        end else begin
            ctrl_q  <= ctrl_d;
            in_high <= hi_d;
            in_low  <= lo_d;
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int N_CORE = 2,
    parameter int DW     = 8,
    parameter int AW     = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic             vec_take,
    input  logic             reti,
    output logic             irq_req,
    output logic [AW-1:0]    vec_addr,
    output logic             in_high,
    output logic             in_low
);

    localparam logic [AW-1:0] VEC_IDLE = AW'(0);
    localparam logic [AW-1:0] VEC_HI   = AW'(8);
    localparam logic [AW-1:0] VEC_LO   = AW'(24);

    reg_sel_e         sel;
    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] flag_q;
    logic [N_SRC-1:0] prio_q;
    ctrl_t            ctrl_q;
    grant_e           grant;
    grant_e           taken;

    assign sel = reg_sel_e'(reg_addr);

    irq_src_bank #(.N_SRC(N_SRC)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt_i),
        .wr_en_reg  (reg_we && sel == REG_EN),
        .wr_flag_reg(reg_we && sel == REG_FLAG),
        .wr_prio_reg(reg_we && sel == REG_PRIO),
        .wdata      (reg_wdata[N_SRC-1:0]),
        .en_q       (en_q),
        .flag_q     (flag_q),
        .prio_q     (prio_q)
    );

    irq_arbiter #(
        .N_SRC   (N_SRC),
        .N_CORE  (N_CORE),
        .AW      (AW),
        .VEC_IDLE(VEC_IDLE),
        .VEC_HI  (VEC_HI),
        .VEC_LO  (VEC_LO)
    ) u_arb (
        .en      (en_q),
        .flag    (flag_q),
        .prio    (prio_q),
        .ctrl    (ctrl_q),
        .in_high (in_high),
        .in_low  (in_low),
        .irq_req (irq_req),
        .vec_addr(vec_addr),
        .grant   (grant)
    );

    assign taken = vec_take ? grant : GRANT_NONE;

    irq_level_ctl u_lvl (
        .clk    (clk),
        .rst    (rst),
        .wr_ctrl(reg_we && sel == REG_CTRL),
        .wbyte  (reg_wdata[7:0]),
        .taken  (taken),
        .reti   (reti),
        .ctrl_q (ctrl_q),
        .in_high(in_high),
        .in_low (in_low)
    );

    always_comb begin
        reg_rdata = '0;
        case (sel)
            REG_CTRL: reg_rdata[7:0]       = ctrl_to_byte(ctrl_q);
            REG_EN:   reg_rdata[N_SRC-1:0] = en_q;
            REG_FLAG: reg_rdata[N_SRC-1:0] = flag_q;
            REG_PRIO: reg_rdata[N_SRC-1:0] = prio_q;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int N_SRC = 8,
    parameter int AW    = 21
) (
    input logic             clk,
    input logic             rst,
    input logic [N_SRC-1:0] en_q,
    input logic [N_SRC-1:0] flag_q,
    input logic             hi_en,
    input logic             lo_en,
    input logic             mode,
    input logic             reg_we,
    input logic [1:0]       reg_addr,
    input logic             vec_take,
    input logic             reti,
    input logic             irq_req,
    input logic [AW-1:0]    vec_addr,
    input logic             in_high,
    input logic             in_low
);

    localparam logic [AW-1:0] HI_A = AW'(8);
    localparam logic [AW-1:0] LO_A = AW'(24);

    logic ctrl_wr;
    assign ctrl_wr = reg_we && reg_addr == 2'd0;

    a_r3_no_pending_no_req: assert property (@(posedge clk) disable iff (rst)
        ((en_q & flag_q) == '0) |-> !irq_req);

    a_r4_single_uses_high: assert property (@(posedge clk) disable iff (rst)
        !mode |-> (vec_addr != LO_A));

    a_r6_take_high: assert property (@(posedge clk) disable iff (rst)
        (irq_req && vec_take && vec_addr == HI_A && !reti && !ctrl_wr)
        |=> (!hi_en && in_high));

    a_r6_take_low: assert property (@(posedge clk) disable iff (rst)
        (irq_req && vec_take && vec_addr == LO_A && !reti && !ctrl_wr)
        |=> (!lo_en && in_low));

    a_r7_no_low_under_high: assert property (@(posedge clk) disable iff (rst)
        in_high |-> !(irq_req && vec_addr == LO_A));

    a_r8_return_restores: assert property (@(posedge clk) disable iff (rst)
        (reti && in_high && !vec_take && !ctrl_wr) |=> (hi_en && !in_high));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N_SRC(N_SRC), .AW(AW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en_q    (en_q),
    .flag_q  (flag_q),
    .hi_en   (ctrl_q.hi_en),
    .lo_en   (ctrl_q.lo_en),
    .mode    (ctrl_q.mode),
    .reg_we  (reg_we),
    .reg_addr(reg_addr),
    .vec_take(vec_take),
    .reti    (reti),
    .irq_req (irq_req),
    .vec_addr(vec_addr),
    .in_high (in_high),
    .in_low  (in_low)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;

    localparam int N_SRC = 8;
    localparam int DW    = 8;
    localparam int AW    = 21;

    logic             clk = 1'b0;
    logic             rst;
    logic [N_SRC-1:0] evt_i;
    logic             reg_we;
    logic [1:0]       reg_addr;
    logic [DW-1:0]    reg_wdata;
    logic [DW-1:0]    reg_rdata;
    logic             vec_take;
    logic             reti;
    logic             irq_req;
    logic [AW-1:0]    vec_addr;
    logic             in_high;
    logic             in_low;

    int nchk = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl #(.N_SRC(N_SRC), .N_CORE(2), .DW(DW), .AW(AW)) dut (
        .clk(clk), .rst(rst), .evt_i(evt_i), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .vec_take(vec_take), .reti(reti), .irq_req(irq_req),
        .vec_addr(vec_addr), .in_high(in_high), .in_low(in_low)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic pulse_evt(logic [7:0] m);
        @(negedge clk);
        evt_i = m;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic do_take();
        @(negedge clk);
        vec_take = 1'b1;
        @(negedge clk);
        vec_take = 1'b0;
    endtask

    task automatic do_reti();
        @(negedge clk);
        reti = 1'b1;
        @(negedge clk);
        reti = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(2'd0, d); chk("R1 ctrl", d, 8'h00);
        rd(2'd2, d); chk("R1 flags", d, 8'h00);
        chk("R1 irq_req", irq_req, 0);
        chk("R1 vec_addr", vec_addr, 0);
        chk("R1 levels", {in_high, in_low}, 0);
    endtask

    task automatic t_regmap();
        logic [7:0] d;
        wr(2'd1, 8'hA5); rd(2'd1, d); chk("R9 enable readback", d, 8'hA5);
        wr(2'd3, 8'h3C); rd(2'd3, d); chk("R9 prio readback", d, 8'h3C);
        wr(2'd0, 8'hFF); rd(2'd0, d); chk("R9 ctrl readback", d, 8'hC1);
        wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd3, 8'h00);
    endtask

    task automatic t_pending_single();
        logic [7:0] d;
        pulse_evt(8'h08);
        rd(2'd2, d); chk("R2 flag set while disabled", d, 8'h08);
        chk("R3 no req without enable", irq_req, 0);
        wr(2'd0, 8'h80);
        chk("R3 global on, source disabled", irq_req, 0);
        wr(2'd1, 8'h08);
        chk("R4 peripheral gated by bit6", irq_req, 0);
        wr(2'd0, 8'hC0);
        chk("R4 peripheral req", irq_req, 1);
        chk("R4 high vector", vec_addr, 21'h8);
        wr(2'd2, 8'h00);
        chk("R2 flag cleared by write", irq_req, 0);
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    endtask

    task automatic t_core_take_return();
        logic [7:0] d;
        wr(2'd0, 8'h80); wr(2'd1, 8'h01);
        pulse_evt(8'h01);
        chk("R4 core source bypasses bit6", irq_req, 1);
        chk("R4 core vector", vec_addr, 21'h8);
        do_take();
        rd(2'd0, d); chk("R6 take clears bit7", d, 8'h00);
        chk("R6 in_high after take", in_high, 1);
        chk("R6 req dropped", irq_req, 0);
        do_reti();
        rd(2'd0, d); chk("R8 reti restores bit7", d, 8'h80);
        chk("R8 in_high cleared", in_high, 0);
        chk("R2 flag still pending after return", irq_req, 1);
        wr(2'd2, 8'h00); wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    endtask

    task automatic t_two_level_nesting();
        logic [7:0] d;
        wr(2'd0, 8'hC1); wr(2'd3, 8'h01); wr(2'd1, 8'h03);
        pulse_evt(8'h02);
        chk("R5 low req", irq_req, 1);
        chk("R5 low vector", vec_addr, 21'h18);
        pulse_evt(8'h01);
        chk("R5 high wins", vec_addr, 21'h8);
        wr(2'd2, 8'h02);
        chk("R5 back to low", vec_addr, 21'h18);
        do_take();
        rd(2'd0, d); chk("R6 take low clears bit6", d, 8'h81);
        chk("R6 in_low after take", in_low, 1);
        chk("R6 low not re-requested", irq_req, 0);
        pulse_evt(8'h01);
        chk("R7 high preempts low routine", irq_req, 1);
        chk("R7 preempt vector", vec_addr, 21'h8);
        do_take();
        rd(2'd0, d); chk("R6 nested take clears bit7", d, 8'h01);
        chk("R7 both levels active", {in_high, in_low}, 2'b11);
        wr(2'd0, 8'h41);
        chk("R7 low blocked under high", irq_req, 0);
        do_reti();
        rd(2'd0, d); chk("R8 nested reti restores bit7", d, 8'hC1);
        chk("R8 low routine survives", {in_high, in_low}, 2'b01);
        chk("R8 pending high again", vec_addr, 21'h8);
        wr(2'd2, 8'h00);
        do_reti();
        chk("R8 low exited", {in_high, in_low}, 2'b00);
        rd(2'd0, d); chk("R8 low gate open", d, 8'hC1);
    endtask

    task automatic t_high_only_blocks_low();
        pulse_evt(8'h01);
        do_take();
        chk("R6 high taken", in_high, 1);
        pulse_evt(8'h02);
        chk("R7 low blocked with bit6 set", irq_req, 0);
        wr(2'd2, 8'h02);
        chk("R7 still blocked", irq_req, 0);
        do_reti();
        chk("R8 low served after return", irq_req, 1);
        chk("R8 low vector after return", vec_addr, 21'h18);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_set_vs_write();
        logic [7:0] d;
        @(negedge clk);
        evt_i = 8'h04; reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h00;
        @(negedge clk);
        evt_i = '0; reg_we = 1'b0;
        rd(2'd2, d); chk("R10 event beats write", d, 8'h04);
        wr(2'd2, 8'h00);
    endtask

    initial begin
        rst = 1'b1; evt_i = '0; reg_we = 1'b0; reg_addr = '0;
        reg_wdata = '0; vec_take = 1'b0; reti = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_pending_single();
        t_core_take_return();
        t_two_level_nesting();
        t_high_only_blocks_low();
        t_set_vs_write();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule